// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits in a byte-wide AXI4-Stream transmit path and performs partial-checksum offload. A separate 32-bit control stream delivers a five-word settings packet ahead of the data. The packet carries an insertion enable, the byte position where summing starts, the byte position that receives the result, and a 16-bit seed. The engine takes in the whole frame and stores it. While the bytes arrive it keeps a running ones-complement sum. It then adds the seed, folds the sum to 16 bits, complements it, and overwrites two bytes of the stored frame with the result. Only after that does it stream the frame out.

Three configuration pins control the frame as a whole. With transmission disabled, frames are accepted and thrown away. With both the oversize and the tagged-frame allowances off, frames of 1519 to 1522 bytes are thrown away. Each frame that is sent raises a one-cycle completion pulse and adds its length to a running byte total.

Top module: `tx_csum_insert`

## Requirements
- R1: After reset, out_tvalid, tx_done and ctl_err are 0, tx_bytes is 0, and in_tready and ctl_tready are 1.
- R2: A control packet of exactly five 32-bit words (word 0 first) is committed at its last beat. Word 0 bit 0 enables insertion. Word 1 bits [31:16] are the start offset and bits [15:0] are the write offset. Word 2 bits [15:0] are the seed. Committed settings apply to every later frame until another good packet replaces them.
- R3: A control packet whose last beat arrives on a word count other than five raises ctl_err for exactly one cycle and leaves the committed settings unchanged.
- R4: With insertion enabled, the checksum is formed as follows. Bytes from the start offset to the end of the frame are taken as big-endian 16-bit words; an odd trailing byte gets a zero low byte. The words are summed, the seed is added, and the result is folded with end-around carry and complemented. Its high byte replaces the byte at the write offset and its low byte replaces the byte at the write offset plus one. The sum uses the unpatched bytes.
- R5: With insertion disabled, the frame leaves unchanged, in order and with its length.
- R6: A patch byte whose position is at or beyond the frame length is not written. A start offset at or beyond the frame length yields the complement of the folded seed.
- R7: With cfg_tx_enable low at the end of a frame, the frame is consumed. No output, no tx_done and no change to tx_bytes follow.
- R8: With cfg_jumbo_ok and cfg_vlan_ok both low, frames of 1519 to 1522 bytes are consumed without output. If either pin is high such frames pass, and 1518 and 1523 byte frames always pass.
- R9: tx_done pulses for one cycle in the cycle after the last output handshake. tx_bytes then has grown by the number of bytes sent.
- R10: out_tvalid stays low until the patch is written. While out_tvalid is high, in_tready and ctl_tready are low. Under back-pressure, out_tdata and out_tlast hold until accepted.
- R11: A frame longer than 2048 bytes is cut to its first 2048 bytes for summing, patching, output and byte counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_enable | input | 1 | Transmit enable; low discards frames |
| cfg_jumbo_ok | input | 1 | Allow frames over the standard length |
| cfg_vlan_ok | input | 1 | Allow tagged-frame lengths (1519 to 1522) |
| ctl_tdata | input | 32 | Control stream word |
| ctl_tvalid | input | 1 | Control word valid |
| ctl_tlast | input | 1 | Last control word |
| ctl_tready | output | 1 | Control word accepted |
| in_tdata | input | 8 | Frame byte in |
| in_tvalid | input | 1 | Frame byte valid |
| in_tlast | input | 1 | Last byte of frame |
| in_tready | output | 1 | Frame byte accepted |
| out_tdata | output | 8 | Frame byte out |
| out_tvalid | output | 1 | Output byte valid |
| out_tlast | output | 1 | Last output byte |
| out_tready | input | 1 | Downstream accepts byte |
| tx_done | output | 1 | One-cycle pulse per frame sent |
| tx_bytes | output | 48 | Running total of bytes sent |
| ctl_err | output | 1 | Pulse on a badly sized control packet |

## Verification
The hardest case to reach from the ports is a malformed control packet that is followed by a frame. The effect of the bad packet shows only in the bytes of that later frame. The bench first commits a known good setting, then sends a short packet and then an over-long packet. Frames sent after each bad packet carry no new settings, and their patched bytes are compared against a model that still uses the earlier settings. A second hard case is the tagged-length window and the buffer cap. These are reached with full-length frames of 1518 to 1523 and 2050 bytes under each combination of the allowance pins.

// File: rtl/csum_pkg.sv
package csum_pkg;

  typedef enum logic [2:0] {
    ST_FILL,
    ST_JUDGE,
    ST_PATCH_HI,
    ST_PATCH_LO,
    ST_PRIME,
    ST_SEND
  } eng_state_t;

  typedef struct packed {
    logic        ins_en;
    logic [15:0] start_off;
    logic [15:0] wr_off;
    logic [15:0] seed;
  } ins_cfg_t;

  // Add seed, fold twice with end-around carry, complement.
  function automatic logic [15:0] fold_csum(input logic [31:0] acc,
                                            input logic [15:0] seed);
    logic [31:0] s;
    logic [16:0] f1;
    logic [15:0] f2;
    s  = acc + {16'h0, seed};
    f1 = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    f2 = f1[15:0] + {15'h0, f1[16]};
    return ~f2;
  endfunction

endpackage

// File: rtl/csum_ctl_rx.sv
module csum_ctl_rx
  import csum_pkg::*;
#(
  parameter int CTL_WORDS = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        accept,
  input  logic [31:0] ctl_tdata,
  input  logic        ctl_tvalid,
  input  logic        ctl_tlast,
  output logic        ctl_tready,
  output ins_cfg_t    cfg,
  output logic        err
);
  localparam int WCW = $clog2(CTL_WORDS + 1) + 1;
  localparam logic [WCW-1:0] LAST_IDX = WCW'(CTL_WORDS - 1);
  localparam logic [WCW-1:0] SAT      = '1;
  localparam logic [WCW-1:0] ONE_W    = WCW'(1);

  logic [WCW-1:0] wcnt;
  ins_cfg_t       shadow, shadow_nxt;
  logic           hs;

  assign ctl_tready = accept;
  assign hs         = ctl_tvalid && accept;

  always_comb begin
    shadow_nxt = shadow;
    if (hs) begin
      case (wcnt)
        WCW'(0): shadow_nxt.ins_en = ctl_tdata[0];
        WCW'(1): begin
          shadow_nxt.start_off = ctl_tdata[31:16];
          shadow_nxt.wr_off    = ctl_tdata[15:0];
        end
        WCW'(2): shadow_nxt.seed = ctl_tdata[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt   <= '0;
      shadow <= '0;
      cfg    <= '0;
      err    <= 1'b0;
    end else begin
      err    <= 1'b0;
      shadow <= shadow_nxt;
      if (hs) begin
        if (ctl_tlast) begin
          wcnt <= '0;
          if (wcnt == LAST_IDX) cfg <= shadow_nxt;
          else                  err <= 1'b1;
        end else if (wcnt != SAT) begin
          wcnt <= wcnt + ONE_W;
        end
      end
    end
  end

  // R3
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(ctl_tvalid && ctl_tready && ctl_tlast));
  // R2
  cfg_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg) |-> $past(hs && ctl_tlast) && !err);

endmodule

// File: rtl/csum_ones_acc.sv
module csum_ones_acc #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          byte_en,
  input  logic [AW-1:0] idx,
  input  logic [15:0]   start,
  input  logic [7:0]    din,
  output logic [31:0]   acc
);
  logic        active;
  logic        low_half;
  logic [31:0] term;

  assign active   = ({{(16-AW){1'b0}}, idx} >= start);
  assign low_half = idx[0] ^ start[0];
  assign term     = low_half ? {24'h0, din} : {16'h0, din, 8'h0};

  always_ff @(posedge clk) begin
    if (rst || clr)            acc <= '0;
    else if (byte_en && active) acc <= acc + term;
  end

  // R4
  acc_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> acc >= $past(acc));

endmodule

// File: rtl/csum_frame_ram.sv
module csum_frame_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tx_csum_insert.sv
module tx_csum_insert
  import csum_pkg::*;
#(
  parameter int BUF_DEPTH = 2048,
  parameter int CNT_W     = 48,
  parameter int STD_MAX   = 1518,
  parameter int TAG_MAX   = 1522,
  parameter int CTL_WORDS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_tx_enable,
  input  logic             cfg_jumbo_ok,
  input  logic             cfg_vlan_ok,
  input  logic [31:0]      ctl_tdata,
  input  logic             ctl_tvalid,
  input  logic             ctl_tlast,
  output logic             ctl_tready,
  input  logic [7:0]       in_tdata,
  input  logic             in_tvalid,
  input  logic             in_tlast,
  output logic             in_tready,
  output logic [7:0]       out_tdata,
  output logic             out_tvalid,
  output logic             out_tlast,
  input  logic             out_tready,
  output logic             tx_done,
  output logic [CNT_W-1:0] tx_bytes,
  output logic             ctl_err
);
  localparam int AW = $clog2(BUF_DEPTH);
  localparam int LW = AW + 1;
  localparam logic [LW-1:0] DEPTH_L = LW'(BUF_DEPTH);
  localparam logic [LW-1:0] STD_L   = LW'(STD_MAX);
  localparam logic [LW-1:0] TAG_L   = LW'(TAG_MAX);
  localparam logic [LW-1:0] ONE_L   = LW'(1);
  localparam logic [LW-1:0] TWO_L   = LW'(2);
  localparam logic [AW-1:0] ONE_A   = AW'(1);

  eng_state_t      state;
  ins_cfg_t        cfg;
  logic [LW-1:0]   fill_len;
  logic [AW-1:0]   rptr;
  logic [15:0]     csum_q;
  logic [31:0]     acc;

  logic            in_hs, take, drop, in_fill;
  logic            hi_ok, lo_ok;
  logic [16:0]     len17, wo17;
  logic [AW-1:0]   wo_a;
  logic            ram_we;
  logic [AW-1:0]   ram_wa, ram_ra;
  logic [7:0]      ram_wd;

  assign in_fill   = (state == ST_FILL);
  assign in_tready = in_fill;
  assign in_hs     = in_tvalid && in_tready;
  assign take      = in_hs && (fill_len < DEPTH_L);

  // Control words are taken only between frames.
  csum_ctl_rx #(.CTL_WORDS(CTL_WORDS)) u_ctl (
    .clk(clk), .rst(rst),
    .accept(in_fill && (fill_len == '0) && !in_tvalid),
    .ctl_tdata(ctl_tdata), .ctl_tvalid(ctl_tvalid), .ctl_tlast(ctl_tlast),
    .ctl_tready(ctl_tready), .cfg(cfg), .err(ctl_err)
  );

  csum_ones_acc #(.AW(AW)) u_acc (
    .clk(clk), .rst(rst),
    .clr(state == ST_JUDGE),
    .byte_en(take),
    .idx(fill_len[AW-1:0]),
    .start(cfg.start_off),
    .din(in_tdata),
    .acc(acc)
  );

  assign drop = !cfg_tx_enable ||
                (!cfg_jumbo_ok && !cfg_vlan_ok &&
                 (fill_len > STD_L) && (fill_len <= TAG_L));

  assign len17 = {{(17-LW){1'b0}}, fill_len};
  assign wo17  = {1'b0, cfg.wr_off};
  assign hi_ok = wo17 < len17;
  assign lo_ok = (wo17 + 17'd1) < len17;
  assign wo_a  = cfg.wr_off[AW-1:0];

  always_comb begin
    ram_we = 1'b0;
    ram_wa = fill_len[AW-1:0];
    ram_wd = in_tdata;
    case (state)
      ST_FILL:     ram_we = take;
      ST_PATCH_HI: begin
        ram_we = hi_ok;
        ram_wa = wo_a;
        ram_wd = csum_q[15:8];
      end
      ST_PATCH_LO: begin
        ram_we = lo_ok;
        ram_wa = wo_a + ONE_A;
        ram_wd = csum_q[7:0];
      end
      default: ;
    endcase
  end

  // Look one byte ahead on an accepted beat so the read register keeps pace.
  assign ram_ra = (state == ST_SEND && out_tready && !out_tlast) ? rptr + ONE_A : rptr;

  csum_frame_ram #(.AW(AW), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_wa), .wdata(ram_wd),
    .raddr(ram_ra), .rdata(out_tdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FILL;
      fill_len   <= '0;
      rptr       <= '0;
      csum_q     <= '0;
      out_tvalid <= 1'b0;
      out_tlast  <= 1'b0;
      tx_done    <= 1'b0;
      tx_bytes   <= '0;
    end else begin
      tx_done <= 1'b0;
      case (state)
        ST_FILL: if (in_hs) begin
          if (take)     fill_len <= fill_len + ONE_L;
          if (in_tlast) state    <= ST_JUDGE;
        end
        ST_JUDGE: begin
          csum_q <= fold_csum(acc, cfg.seed);
          rptr   <= '0;
          if (drop) begin
            fill_len <= '0;
            state    <= ST_FILL;
          end else if (cfg.ins_en) begin
            state <= ST_PATCH_HI;
          end else begin
            state <= ST_PRIME;
          end
        end
        ST_PATCH_HI: state <= ST_PATCH_LO;
        ST_PATCH_LO: state <= ST_PRIME;
        ST_PRIME: begin
          out_tvalid <= 1'b1;
          out_tlast  <= (fill_len == ONE_L);
          state      <= ST_SEND;
        end
        ST_SEND: if (out_tready) begin
          if (out_tlast) begin
            out_tvalid <= 1'b0;
            out_tlast  <= 1'b0;
            tx_done    <= 1'b1;
            tx_bytes   <= tx_bytes + {{(CNT_W-LW){1'b0}}, fill_len};
            fill_len   <= '0;
            state      <= ST_FILL;
          end else begin
            rptr      <= rptr + ONE_A;
            out_tlast <= (({1'b0, rptr} + TWO_L) == fill_len);
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_tvalid && !out_tready |=> out_tvalid && $stable(out_tdata) && $stable(out_tlast));
  // R10
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    out_tvalid |-> !in_tready && !ctl_tready);
  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> $past(out_tvalid && out_tready && out_tlast));
  // R9
  bytes_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_bytes) |-> tx_done);
  // R11
  len_cap_chk: assert property (@(posedge clk) disable iff (rst)
    in_hs && !take |-> fill_len == DEPTH_L);

endmodule

// File: tb/tb_tx_csum_insert.sv
module tb_tx_csum_insert;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_tx_enable = 1'b1, cfg_jumbo_ok = 1'b0, cfg_vlan_ok = 1'b0;
  logic [31:0] ctl_tdata = '0;
  logic        ctl_tvalid = 1'b0, ctl_tlast = 1'b0, ctl_tready;
  logic [7:0]  in_tdata = '0;
  logic        in_tvalid = 1'b0, in_tlast = 1'b0, in_tready;
  logic [7:0]  out_tdata;
  logic        out_tvalid, out_tlast;
  logic        out_tready;
  logic        tx_done, ctl_err;
  logic [47:0] tx_bytes;

  always #5 clk = ~clk;

  tx_csum_insert dut (
    .clk(clk), .rst(rst),
    .cfg_tx_enable(cfg_tx_enable), .cfg_jumbo_ok(cfg_jumbo_ok), .cfg_vlan_ok(cfg_vlan_ok),
    .ctl_tdata(ctl_tdata), .ctl_tvalid(ctl_tvalid), .ctl_tlast(ctl_tlast), .ctl_tready(ctl_tready),
    .in_tdata(in_tdata), .in_tvalid(in_tvalid), .in_tlast(in_tlast), .in_tready(in_tready),
    .out_tdata(out_tdata), .out_tvalid(out_tvalid), .out_tlast(out_tlast), .out_tready(out_tready),
    .tx_done(tx_done), .tx_bytes(tx_bytes), .ctl_err(ctl_err)
  );

  typedef struct packed {
    logic [15:0] len;
    logic        ins;
    logic [15:0] so;
    logic [15:0] wo;
    logic [15:0] seed;
    logic        txen;
    logic        jum;
    logic        vlan;
    logic        bp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'd60,   1'b1, 16'd14, 16'd50,  16'h1234, 1'b1, 1'b1, 1'b1, 1'b0},
    '{16'd61,   1'b1, 16'd20, 16'd24,  16'hffff, 1'b1, 1'b0, 1'b0, 1'b1},
    '{16'd40,   1'b0, 16'd14, 16'd16,  16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'd30,   1'b1, 16'd10, 16'd29,  16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'd20,   1'b1, 16'd25, 16'd2,   16'habcd, 1'b1, 1'b0, 1'b0, 1'b1},
    '{16'd50,   1'b1, 16'd0,  16'd4,   16'h0000, 1'b0, 1'b1, 1'b1, 1'b0},
    '{16'd1519, 1'b0, 16'd0,  16'd0,   16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'd1522, 1'b0, 16'd0,  16'd0,   16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'd1518, 1'b1, 16'd14, 16'd1516,16'h0001, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'd1523, 1'b0, 16'd0,  16'd0,   16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'd1520, 1'b0, 16'd0,  16'd0,   16'h0000, 1'b1, 1'b0, 1'b1, 1'b0},
    '{16'd1521, 1'b1, 16'd0,  16'd8,   16'h5555, 1'b1, 1'b1, 1'b0, 1'b1},
    '{16'd2050, 1'b1, 16'd34, 16'd100, 16'h0f0f, 1'b1, 1'b1, 1'b1, 1'b0},
    '{16'd1,    1'b1, 16'd0,  16'd0,   16'h0000, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  int n_chk = 0, n_fail = 0;
  int ocnt = 0, done_cnt = 0, err_cnt = 0, viol_cnt = 0, cyc = 0;
  bit bp_mode = 1'b0;
  logic [7:0]  obuf  [4096];
  logic [7:0]  exp_b [4096];
  int          exp_len;
  logic [47:0] exp_bytes = '0;
  bit          prev_stall = 1'b0;
  logic [7:0]  prev_d = '0;
  logic        prev_l = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Output monitor: drives out_tready and samples at the falling edge.
  always @(negedge clk) begin
    cyc++;
    out_tready = bp_mode ? (cyc % 3 != 0) : 1'b1;
    if (!rst) begin
      if (prev_stall && (!out_tvalid || out_tdata != prev_d || out_tlast != prev_l))
        viol_cnt++;
      if (out_tvalid && (in_tready || ctl_tready)) viol_cnt++;
      if (out_tvalid && out_tready) begin
        obuf[ocnt] = out_tdata;
        ocnt++;
      end
      if (tx_done) done_cnt++;
      if (ctl_err) err_cnt++;
      prev_stall = out_tvalid && !out_tready;
      prev_d     = out_tdata;
      prev_l     = out_tlast;
    end
  end

  function automatic logic [7:0] gen(input int i, input int k);
    int v;
    v = i * 37 + k * 11 + 3;
    return v[7:0];
  endfunction

  task automatic model(input int len, input bit ins, input int so, input int wo,
                       input int seed, input int k);
    int eff;
    longint acc;
    logic [15:0] cs;
    eff = (len > 2048) ? 2048 : len;
    for (int i = 0; i < eff; i++) exp_b[i] = gen(i, k);
    acc = 0;
    for (int i = so; i < eff; i++)
      acc += (((i - so) % 2) == 0) ? longint'(exp_b[i]) * 256 : longint'(exp_b[i]);
    acc += seed;
    while ((acc >> 16) != 0) acc = (acc & 64'hffff) + (acc >> 16);
    cs = ~acc[15:0];
    if (ins) begin
      if (wo < eff)     exp_b[wo]     = cs[15:8];
      if (wo + 1 < eff) exp_b[wo + 1] = cs[7:0];
    end
    exp_len = eff;
  endtask

  task automatic send_ctl(input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input int n);
    for (int i = 0; i < n; i++) begin
      ctl_tdata  = (i == 0) ? w0 : (i == 1) ? w1 : (i == 2) ? w2 : 32'h0;
      ctl_tvalid = 1'b1;
      ctl_tlast  = (i == n - 1);
      while (!ctl_tready) @(negedge clk);
      @(negedge clk);
    end
    ctl_tvalid = 1'b0;
    ctl_tlast  = 1'b0;
  endtask

  task automatic send_frame(input int len, input int k);
    for (int i = 0; i < len; i++) begin
      in_tdata  = gen(i, k);
      in_tvalid = 1'b1;
      in_tlast  = (i == len - 1);
      while (!in_tready) @(negedge clk);
      @(negedge clk);
    end
    in_tvalid = 1'b0;
    in_tlast  = 1'b0;
  endtask

  // Sends one frame and checks it against the model.
  task automatic run_frame(input int len, input int k, input bit drop, input string req);
    int d0, mism, t;
    ocnt = 0;
    d0   = done_cnt;
    send_frame(len, k);
    if (drop) begin
      repeat (30) @(negedge clk);
      chk(ocnt == 0, req, "discarded frame produced bytes", ocnt, 0);
      chk(done_cnt == d0 && tx_bytes == exp_bytes, req, "discarded frame counted",
          tx_bytes, exp_bytes);
    end else begin
      t = 0;
      while (done_cnt == d0 && t < 20000) begin
        @(negedge clk);
        t++;
      end
      chk(done_cnt == d0 + 1, "R9", "tx_done pulses", done_cnt - d0, 1);
      chk(ocnt == exp_len, req, "output length", ocnt, exp_len);
      mism = 0;
      for (int i = 0; i < exp_len; i++) if (obuf[i] !== exp_b[i]) mism++;
      chk(mism == 0, req, "mismatched bytes", mism, 0);
      exp_bytes += 48'(exp_len);
      chk(tx_bytes == exp_bytes, "R9", "tx_bytes total", tx_bytes, exp_bytes);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    int e0;
    bit drop;
    string req;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk(out_tvalid == 1'b0, "R1", "out_tvalid", out_tvalid, 0);
    chk(tx_done == 1'b0 && ctl_err == 1'b0, "R1", "pulses idle", tx_done, 0);
    chk(tx_bytes == 48'd0, "R1", "tx_bytes", tx_bytes, 0);
    chk(in_tready && ctl_tready, "R1", "ready outputs", in_tready, 1);

    for (int v = 0; v < NV; v++) begin
      cfg_tx_enable = VECS[v].txen;
      cfg_jumbo_ok  = VECS[v].jum;
      cfg_vlan_ok   = VECS[v].vlan;
      bp_mode       = VECS[v].bp;
      send_ctl({31'h0, VECS[v].ins}, {VECS[v].so, VECS[v].wo}, {16'h0, VECS[v].seed}, 5);
      model(int'(VECS[v].len), VECS[v].ins, int'(VECS[v].so), int'(VECS[v].wo),
            int'(VECS[v].seed), v);
      drop = !VECS[v].txen ||
             (!VECS[v].jum && !VECS[v].vlan && exp_len > 1518 && exp_len <= 1522);
      if (!VECS[v].txen)                       req = "R7";
      else if (exp_len >= 1518 && exp_len <= 1523) req = "R8";
      else if (VECS[v].len > 2048)             req = "R11";
      else if (!VECS[v].ins)                   req = "R5";
      else if (VECS[v].so >= VECS[v].len || VECS[v].wo + 1 >= VECS[v].len) req = "R6";
      else                                     req = "R4";
      run_frame(int'(VECS[v].len), v, drop, req);
    end
    bp_mode = 1'b0;
    cfg_tx_enable = 1'b1;

    // R2 / R3: good settings, then bad packets must not replace them
    e0 = err_cnt;
    send_ctl(32'h1, {16'd14, 16'd16}, 32'h1111, 5);
    send_ctl(32'h0, {16'd0, 16'd0}, 32'h0005, 3);
    repeat (2) @(negedge clk);
    chk(err_cnt == e0 + 1, "R3", "short control packet error pulses", err_cnt - e0, 1);
    model(64, 1'b1, 14, 16, 16'h1111, 40);
    run_frame(64, 40, 1'b0, "R3");
    send_ctl(32'h0, {16'd2, 16'd3}, 32'h0009, 6);
    repeat (2) @(negedge clk);
    chk(err_cnt == e0 + 2, "R3", "long control packet error pulses", err_cnt - e0, 2);
    model(33, 1'b1, 14, 16, 16'h1111, 41);
    run_frame(33, 41, 1'b0, "R2");

    chk(viol_cnt == 0, "R10", "hold or exclusion violations", viol_cnt, 0);
    summary();
    $finish;
  end

endmodule